// File: doc/BRIEF.md
# SPI Master Register and Receive Buffer Front End

This block is the bus-facing half of an SPI master. It holds a control word, a baud-rate divisor, a status word and a receive buffer, all in a 64-byte register window. Software writes a word to the buffer location to start a transfer. The block splits that word into 1, 2 or 4 bytes and sends them most significant byte first to an external shift engine, using a byte-level valid/acknowledge handshake. It packs the returned bytes into a received word and stores it in the receive buffer.

The buffer has two modes. In plain mode it is a single slot. In enhanced mode it is a small circular queue. The block tracks a receive-full flag and an overflow flag. It drives three interrupt requests: fault, transmit and receive. The control, status and divisor locations accept assign, clear, set and invert writes, so software can change single bits without a read-modify-write. Baud-rate clock generation and pin-level shifting are handled elsewhere.

Top module: `spi_regfront`

## Requirements
- R1: Address bits [5:4] select the register: 0 control, 1 status, 2 buffer, 3 divisor. A read at or above byte address 0x40 returns zero. A write there changes nothing.
- R2: On control and divisor writes, address bits [3:2] choose the operation: 00 assigns the written value, 01 clears the bits written as 1, 10 sets them, 11 inverts them.
- R3: In the status word, only the overflow bit (bit 6) can be changed by a write. Receive-full (bit 0) and transmit-empty (bit 3) keep their hardware values under any operation.
- R4: A control write that leaves the enable bit (control bit 15) at 0 clears receive-full and overflow. Status then reads 0x8.
- R5: A control write that leaves enable at 1 and enhanced mode (control bit 16) at 0 returns both queue pointers to entry 0.
- R6: A buffer read returns the entry at the read pointer and clears receive-full. The read pointer advances, wrapping after 4 entries, only in enhanced mode.
- R7: A completed word is always stored at the write pointer. If receive-full was already set, overflow is set and the pointer holds. Otherwise, in enhanced mode the write pointer advances and receive-full is set only when it meets the read pointer; in plain mode receive-full is set.
- R8: Control bit 11 selects 4 bytes per word; otherwise control bit 10 selects 2; otherwise 1 byte is used. Bytes go out from the most significant byte of the selected low part of the word. Returned bytes fill the same positions, and unused upper bits read 0.
- R9: When slave_present is low, a buffer write sends no bytes and stores 0xFFFFFFFF.
- R10: After reset, control and divisor read 0, status reads 0x8, and both pointers are at entry 0.
- R11: tx_valid stays high with tx_byte unchanged until rx_valid acknowledges the byte. bus_ready stays low from the start of a transfer until its last byte is acknowledged.
- R12: With enable set, irq_rx follows receive-full, irq_fault follows overflow, and irq_tx is high while no transfer is active. With enable clear, all three are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Bus access request, accepted only while bus_ready is high |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 9 | Byte address inside the peripheral |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | High when a request can be taken; low during a transfer |
| bus_rdata | output | 32 | Read data, valid the cycle after the read is accepted |
| slave_present | input | 1 | A slave is attached to the port |
| tx_byte | output | 8 | Byte offered to the shift engine |
| tx_valid | output | 1 | tx_byte is valid and awaits acknowledgement |
| rx_byte | input | 8 | Byte returned by the shift engine |
| rx_valid | input | 1 | Acknowledge: rx_byte holds the answer to tx_byte |
| irq_fault | output | 1 | Overflow interrupt request |
| irq_tx | output | 1 | Transmit-ready interrupt request |
| irq_rx | output | 1 | Receive-full interrupt request |

## Verification
The assertions assume two things about the inputs. The bus master raises bus_req only while bus_ready is high. The shift engine pulses rx_valid only while tx_valid is high. If either rule is broken, the request is lost or a byte is skipped without any error being flagged.

The stimulus keeps to both rules. Every bus task waits for bus_ready before it drives a request. The engine model answers only a byte it has seen offered, after a fixed delay, for exactly one cycle. With those rules in place, the properties on handshake stability, stalling, overflow and flag clearing can be judged against the block's own behaviour.

// File: rtl/spi_regfront_pkg.sv
package spi_regfront_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    OP_ASSIGN = 2'b00,
    OP_CLEAR  = 2'b01,
    OP_SET    = 2'b10,
    OP_INVERT = 2'b11
  } wr_op_e;

  typedef enum logic [2:0] {
    SEL_CTL,
    SEL_STAT,
    SEL_BUF,
    SEL_DIV,
    SEL_NONE
  } reg_sel_e;

  localparam int CTL_ON  = 15;
  localparam int CTL_ENH = 16;
  localparam int CTL_W32 = 11;
  localparam int CTL_W16 = 10;

  localparam int ST_RBF = 0;
  localparam int ST_TBE = 3;
  localparam int ST_ROV = 6;

  function automatic logic [DATA_W-1:0] apply_op(input logic [DATA_W-1:0] cur,
                                                 input logic [DATA_W-1:0] val,
                                                 input wr_op_e op);
    case (op)
      OP_ASSIGN: apply_op = val;
      OP_CLEAR:  apply_op = cur & ~val;
      OP_SET:    apply_op = cur | val;
      default:   apply_op = cur ^ val;
    endcase
  endfunction
endpackage

// File: rtl/spi_atomic_reg.sv
module spi_atomic_reg
  import spi_regfront_pkg::*;
#(
  parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  wr_op_e            op,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q,
  output logic [DATA_W-1:0] nxt
);
  assign nxt = apply_op(q, wdata, op);

  always_ff @(posedge clk) begin
    if (rst)        q <= RESET_VAL;
    else if (wr_en) q <= nxt;
  end
endmodule

// File: rtl/spi_rxfifo.sv
module spi_rxfifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  input  logic         enh,
  input  logic         ptr_clear,
  input  logic         flags_clear,
  input  logic         rov_we,
  input  logic         rov_wval,
  output logic [W-1:0] rd_data,
  output logic         rbf,
  output logic         rov
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic [PTR_W-1:0] wptr_inc, rptr_inc;

  function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) wrap_inc = '0;
    else                        wrap_inc = p + 1'b1;
  endfunction

  assign wptr_inc = wrap_inc(wptr);
  assign rptr_inc = wrap_inc(rptr);

  // storage kept free of reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= push_data;
    if (pop)  rd_data   <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      rbf  <= 1'b0;
      rov  <= 1'b0;
    end else begin
      if (flags_clear) begin
        rbf <= 1'b0;
        rov <= 1'b0;
      end
      if (ptr_clear) begin
        wptr <= '0;
        rptr <= '0;
      end
      if (rov_we) rov <= rov_wval;
      if (pop) begin
        if (enh) rptr <= rptr_inc;
        rbf <= 1'b0;
      end
      if (push) begin
        if (rbf) begin
          rov <= 1'b1;
        end else if (enh) begin
          wptr <= wptr_inc;
          if (wptr_inc == rptr) rbf <= 1'b1;
        end else begin
          rbf <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_xfer.sv
module spi_xfer #(
  parameter int W = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic [$clog2(W/8+1)-1:0]     nbytes,
  input  logic [W-1:0]                 wdata,
  output logic [7:0]                   tx_byte,
  output logic                         tx_valid,
  input  logic [7:0]                   rx_byte,
  input  logic                         rx_valid,
  output logic                         done,
  output logic [W-1:0]                 word
);
  localparam int BYTES = W / 8;
  localparam int CNT_W = $clog2(BYTES + 1);

  logic [W-1:0]     tx_sh, acc, tx_load;
  logic [CNT_W-1:0] left;
  logic             active, ack;

  always_comb begin
    int sh;
    sh      = 8 * (BYTES - int'(nbytes));
    tx_load = wdata << sh;
  end

  assign ack      = active & rx_valid;
  assign done     = ack & (left == CNT_W'(1));
  assign word     = {acc[W-9:0], rx_byte};
  assign tx_valid = active;
  assign tx_byte  = tx_sh[W-1:W-8];

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh  <= '0;
      acc    <= '0;
      left   <= '0;
      active <= 1'b0;
    end else if (start) begin
      tx_sh  <= tx_load;
      acc    <= '0;
      left   <= nbytes;
      active <= 1'b1;
    end else if (ack) begin
      tx_sh <= tx_sh << 8;
      acc   <= word;
      left  <= left - 1'b1;
      if (left == CNT_W'(1)) active <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_regfront.sv
module spi_regfront
  import spi_regfront_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int FIFO_DEPTH = 4,
  parameter int WINDOW     = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              bus_ready,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              slave_present,
  output logic [7:0]        tx_byte,
  output logic              tx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              rx_valid,
  output logic              irq_fault,
  output logic              irq_tx,
  output logic              irq_rx
);
  localparam int CNT_W = $clog2(DATA_W/8 + 1);

  reg_sel_e          sel, sel_q;
  wr_op_e            op;
  logic              in_win, wr, rd, busy;
  logic              ctl_we, div_we, stat_we, buf_wr, buf_rd;
  logic [DATA_W-1:0] ctl_q, ctl_nxt, div_q, div_nxt, stat_word, stat_new;
  logic [DATA_W-1:0] rdata_q, fifo_rd, xfer_word, push_data;
  logic              fifo_rbf, fifo_rov, push, xfer_done, xfer_start;
  logic              flags_clear, ptr_clear;
  logic [CNT_W-1:0]  nbytes;

  assign in_win = bus_addr < ADDR_W'(WINDOW);
  assign op     = wr_op_e'(bus_addr[3:2]);

  always_comb begin
    sel = SEL_NONE;
    if (in_win) begin
      case (bus_addr[5:4])
        2'd0:    sel = SEL_CTL;
        2'd1:    sel = SEL_STAT;
        2'd2:    sel = SEL_BUF;
        default: sel = SEL_DIV;
      endcase
    end
  end

  assign bus_ready = ~busy;
  assign wr        = bus_req & bus_we  & bus_ready;
  assign rd        = bus_req & ~bus_we & bus_ready;
  assign ctl_we    = wr & (sel == SEL_CTL);
  assign div_we    = wr & (sel == SEL_DIV);
  assign stat_we   = wr & (sel == SEL_STAT);
  assign buf_wr    = wr & (sel == SEL_BUF);
  assign buf_rd    = rd & (sel == SEL_BUF);

  spi_atomic_reg u_ctl (
    .clk(clk), .rst(rst), .wr_en(ctl_we), .op(op), .wdata(bus_wdata),
    .q(ctl_q), .nxt(ctl_nxt)
  );

  spi_atomic_reg u_div (
    .clk(clk), .rst(rst), .wr_en(div_we), .op(op), .wdata(bus_wdata),
    .q(div_q), .nxt(div_nxt)
  );

  assign flags_clear = ctl_we & ~ctl_nxt[CTL_ON];
  assign ptr_clear   = ctl_we & ctl_nxt[CTL_ON] & ~ctl_nxt[CTL_ENH];

  always_comb begin
    if (ctl_q[CTL_W32])      nbytes = CNT_W'(4);
    else if (ctl_q[CTL_W16]) nbytes = CNT_W'(2);
    else                     nbytes = CNT_W'(1);
  end

  assign xfer_start = buf_wr & slave_present;

  spi_xfer #(.W(DATA_W)) u_xfer (
    .clk(clk), .rst(rst), .start(xfer_start), .nbytes(nbytes),
    .wdata(bus_wdata), .tx_byte(tx_byte), .tx_valid(tx_valid),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .done(xfer_done), .word(xfer_word)
  );

  assign busy      = tx_valid;
  assign push      = xfer_done | (buf_wr & ~slave_present);
  assign push_data = xfer_done ? xfer_word : '1;

  always_comb begin
    stat_word         = '0;
    stat_word[ST_RBF] = fifo_rbf;
    stat_word[ST_TBE] = ~busy;
    stat_word[ST_ROV] = fifo_rov;
  end
  assign stat_new = apply_op(stat_word, bus_wdata, op);

  spi_rxfifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .push_data(push_data), .pop(buf_rd),
    .enh(ctl_q[CTL_ENH]), .ptr_clear(ptr_clear), .flags_clear(flags_clear),
    .rov_we(stat_we), .rov_wval(stat_new[ST_ROV]), .rd_data(fifo_rd),
    .rbf(fifo_rbf), .rov(fifo_rov)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      sel_q   <= SEL_NONE;
    end else if (rd) begin
      sel_q <= sel;
      case (sel)
        SEL_CTL:  rdata_q <= ctl_q;
        SEL_STAT: rdata_q <= stat_word;
        SEL_DIV:  rdata_q <= div_q;
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata = (sel_q == SEL_BUF) ? fifo_rd : rdata_q;

  assign irq_rx    = ctl_q[CTL_ON] & fifo_rbf;
  assign irq_fault = ctl_q[CTL_ON] & fifo_rov;
  assign irq_tx    = ctl_q[CTL_ON] & ~busy;
endmodule

// File: rtl/spi_regfront_chk.sv
module spi_regfront_chk #(
  parameter int ADDR_W = 9,
  parameter int WINDOW = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_ready,
  input logic [31:0]       bus_rdata,
  input logic              slave_present,
  input logic [7:0]        tx_byte,
  input logic              tx_valid,
  input logic              rx_valid,
  input logic              irq_fault,
  input logic              irq_tx,
  input logic              irq_rx,
  input logic              ctl_on,
  input logic              rbf,
  input logic              push
);
  logic acc_ok, out_win, is_buf, is_stat;
  assign acc_ok  = bus_req & bus_ready;
  assign out_win = bus_addr >= ADDR_W'(WINDOW);
  assign is_buf  = !out_win && bus_addr[5:4] == 2'd2;
  assign is_stat = !out_win && bus_addr[5:4] == 2'd1;

  // R11 input rule: requests only while ready
  req_rule_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> bus_ready);

  // R11 input rule: acknowledge only an offered byte
  ack_rule_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> tx_valid);

  // R11
  hold_byte_chk: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !rx_valid |=> tx_valid && $stable(tx_byte));

  // R11
  stall_chk: assert property (@(posedge clk) disable iff (rst)
    acc_ok && bus_we && is_buf && slave_present |=> !bus_ready);

  // R1
  window_chk: assert property (@(posedge clk) disable iff (rst)
    acc_ok && !bus_we && out_win |=> bus_rdata == 32'h0);

  // R6
  pop_clear_chk: assert property (@(posedge clk) disable iff (rst)
    acc_ok && !bus_we && is_buf |=> !rbf);

  // R7
  overflow_chk: assert property (@(posedge clk) disable iff (rst)
    push && rbf |=> irq_fault || !ctl_on);

  // R3
  stat_ro_chk: assert property (@(posedge clk) disable iff (rst)
    acc_ok && bus_we && is_stat |=> rbf == $past(rbf));

  // R12
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl_on |-> !irq_rx && !irq_fault && !irq_tx);
endmodule

bind spi_regfront spi_regfront_chk #(.ADDR_W(ADDR_W), .WINDOW(WINDOW)) u_chk (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_ready(bus_ready), .bus_rdata(bus_rdata), .slave_present(slave_present),
  .tx_byte(tx_byte), .tx_valid(tx_valid), .rx_valid(rx_valid),
  .irq_fault(irq_fault), .irq_tx(irq_tx), .irq_rx(irq_rx),
  .ctl_on(ctl_q[15]), .rbf(fifo_rbf), .push(push)
);

// File: tb/spi_regfront_tb.sv
module spi_regfront_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_req, bus_we;
  logic [8:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_ready;
  logic [31:0] bus_rdata;
  logic        slave_present;
  logic [7:0]  tx_byte, rx_byte;
  logic        tx_valid, rx_valid;
  logic        irq_fault, irq_tx, irq_rx;

  int checks = 0, errors = 0, nseen = 0;
  bit finished = 0;
  logic [7:0] seen [64];

  localparam logic [31:0] ON = 32'h8000, ENH = 32'h10000, W32 = 32'h800, W16 = 32'h400;

  always #2.5 clk = ~clk;

  spi_regfront u_dut (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
    .slave_present(slave_present), .tx_byte(tx_byte), .tx_valid(tx_valid),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .irq_fault(irq_fault),
    .irq_tx(irq_tx), .irq_rx(irq_rx)
  );

  // shift engine model: answers each byte with byte ^ 0xA5
  initial begin
    rx_valid = 1'b0;
    rx_byte  = 8'h00;
    forever begin
      @(negedge clk);
      if (tx_valid) begin
        seen[nseen % 64] = tx_byte;
        nseen++;
        repeat (2) @(negedge clk);
        rx_byte  = tx_byte ^ 8'hA5;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
      end
    end
  end

  function automatic logic [31:0] exch(input logic [31:0] w, input int n);
    logic [31:0] r = 32'h0;
    for (int i = n - 1; i >= 0; i--) r = (r << 8) | 32'(w[8*i +: 8] ^ 8'hA5);
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_ready();
    while (!bus_ready) @(negedge clk);
  endtask

  task automatic bus_write(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    wait_ready();
    bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 0; bus_we = 0;
  endtask

  task automatic bus_read(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    wait_ready();
    bus_req = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_req = 0;
    d = bus_rdata;
  endtask

  task automatic xfer(input logic [31:0] d);
    bus_write(9'h020, d);
    wait_ready();
  endtask

  task automatic expect_reg(input string req, input logic [8:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus_read(a, v);
    check(req, v, exp);
  endtask

  task automatic t_reset();
    check("R10 bus_ready", 32'(bus_ready), 32'h1);
    expect_reg("R10 control", 9'h000, 32'h0);
    expect_reg("R10 status", 9'h010, 32'h8);
    expect_reg("R10 divisor", 9'h030, 32'h0);
    check("R12 irqs off", {29'h0, irq_fault, irq_tx, irq_rx}, 32'h0);
  endtask

  task automatic t_atomic();
    bus_write(9'h030, 32'h00F0); expect_reg("R2 assign", 9'h030, 32'h00F0);
    bus_write(9'h038, 32'h000F); expect_reg("R2 set", 9'h030, 32'h00FF);
    bus_write(9'h034, 32'h0030); expect_reg("R2 clear", 9'h030, 32'h00CF);
    bus_write(9'h03C, 32'h00FF); expect_reg("R2 invert", 9'h030, 32'h0030);
    bus_write(9'h008, ON);       expect_reg("R2 control set", 9'h000, ON);
    check("R12 irq_tx idle", 32'(irq_tx), 32'h1);
  endtask

  task automatic t_window();
    expect_reg("R1 read 0x40", 9'h040, 32'h0);
    expect_reg("R1 read 0x1F0", 9'h1F0, 32'h0);
    bus_write(9'h040, 32'hFFFF);
    bus_write(9'h070, 32'hFFFF);
    expect_reg("R1 ignored write", 9'h030, 32'h0030);
  endtask

  task automatic t_byte_mode();
    int base;
    bus_write(9'h000, ON);
    base = nseen;
    xfer(32'h12345678);
    check("R8 one byte sent", 32'(nseen - base), 32'h1);
    check("R8 low byte", 32'(seen[base % 64]), 32'h78);
    expect_reg("R7 rbf plain", 9'h010, 32'h9);
    check("R12 irq_rx", 32'(irq_rx), 32'h1);
    expect_reg("R6 read word", 9'h020, 32'h000000DD);
    expect_reg("R6 rbf cleared", 9'h010, 32'h8);
  endtask

  task automatic t_overflow();
    xfer(32'h11);
    xfer(32'h22);
    expect_reg("R7 overflow", 9'h010, 32'h49);
    check("R12 irq_fault", 32'(irq_fault), 32'h1);
    bus_write(9'h01C, 32'h1);
    expect_reg("R3 rbf not writable", 9'h010, 32'h49);
    bus_write(9'h014, 32'h40);
    expect_reg("R3 rov cleared", 9'h010, 32'h09);
    expect_reg("R7 overwritten slot", 9'h020, exch(32'h22, 1));
  endtask

  task automatic t_widths();
    int base;
    bus_write(9'h000, ON | W32);
    base = nseen;
    xfer(32'h12345678);
    check("R8 four bytes", 32'(nseen - base), 32'h4);
    for (int k = 0; k < 4; k++)
      check("R8 byte order 32", 32'(seen[(base + k) % 64]), 32'(8'h12 + 8'h22 * k[7:0]));
    expect_reg("R8 word 32", 9'h020, exch(32'h12345678, 4));
    bus_write(9'h000, ON | W16);
    base = nseen;
    xfer(32'hFFFFABCD);
    check("R8 two bytes", 32'(nseen - base), 32'h2);
    check("R8 first 16", 32'(seen[base % 64]), 32'hAB);
    expect_reg("R8 word 16", 9'h020, 32'h00000E68);
  endtask

  task automatic t_enhanced();
    bus_write(9'h000, ON);
    bus_write(9'h000, ON | ENH);
    xfer(32'h01); xfer(32'h02); xfer(32'h03);
    expect_reg("R7 not full at 3", 9'h010, 32'h8);
    xfer(32'h04);
    expect_reg("R7 full at 4", 9'h010, 32'h9);
    xfer(32'h05);
    expect_reg("R7 enh overflow", 9'h010, 32'h49);
    expect_reg("R6 enh read 1", 9'h020, exch(32'h05, 1));
    expect_reg("R6 rbf after read", 9'h010, 32'h48);
    expect_reg("R6 enh read 2", 9'h020, exch(32'h02, 1));
    expect_reg("R6 enh read 3", 9'h020, exch(32'h03, 1));
    expect_reg("R6 enh read 4", 9'h020, exch(32'h04, 1));
    bus_write(9'h014, 32'h40);
  endtask

  task automatic t_ptr_clear();
    xfer(32'h06); xfer(32'h07);
    expect_reg("R6 enh read 6", 9'h020, exch(32'h06, 1));
    bus_write(9'h000, ON);
    xfer(32'h08);
    expect_reg("R5 pointers cleared", 9'h020, exch(32'h08, 1));
  endtask

  task automatic t_no_slave();
    int base;
    slave_present = 0;
    base = nseen;
    xfer(32'h55);
    check("R9 nothing sent", 32'(nseen - base), 32'h0);
    expect_reg("R9 all ones", 9'h020, 32'hFFFFFFFF);
    slave_present = 1;
  endtask

  task automatic t_busy();
    bus_write(9'h000, ON | W32);
    bus_write(9'h020, 32'hCAFEF00D);
    check("R11 ready low", 32'(bus_ready), 32'h0);
    check("R12 irq_tx busy", 32'(irq_tx), 32'h0);
    wait_ready();
    check("R11 ready after", 32'(bus_ready), 32'h1);
    expect_reg("R11 word", 9'h020, exch(32'hCAFEF00D, 4));
  endtask

  task automatic t_disable();
    xfer(32'h1); xfer(32'h2);
    expect_reg("R4 before", 9'h010, 32'h49);
    bus_write(9'h004, ON);
    expect_reg("R4 control off", 9'h000, W32);
    expect_reg("R4 status forced", 9'h010, 32'h8);
    check("R12 irqs disabled", {29'h0, irq_fault, irq_tx, irq_rx}, 32'h0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1; bus_req = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0; slave_present = 1;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_atomic();
    t_window();
    t_byte_mode();
    t_overflow();
    t_widths();
    t_enhanced();
    t_ptr_clear();
    t_no_slave();
    t_busy();
    t_disable();
    finish_run();
  end
endmodule